// File: doc/BRIEF.md
# Double-Sampling Pipeline Register Fabric with Error Recovery

This block holds the stage registers of a short in-order pipeline: fetch, decode, execute and memory. Every stage register is paired with a shadow register. The main register captures the value that arrives on time. The shadow register captures a second copy of the same value that is allowed to settle later. The shadow copy is trusted. When the two copies disagree, the stage has seen a timing error. The stage then reloads its main register from the shadow and holds for one cycle. It sends a bubble to the stage below it. It also starts a flush that moves toward fetch by one stage per cycle. A flush passes only between neighbouring stages, so no global stall wire exists.

When the flush reaches fetch, the fetch program counter is reloaded with the address that follows the faulting instruction. The instructions that were squashed are then fetched again. A writeback register without a shadow sits after the memory stage. It only ever receives values that have already been checked or restored. Each stage takes its on-time and late data from ports, so a testbench can create timing errors at will. Stage index 0 is fetch and index NS-1 is memory. A larger index means an older instruction.

Top module: `dsamp_pipe`

## Requirements
- R1: While rst_ni is low, all stage valid bits, error flags, flush flags, restart_o and wb_vld_o read 0. On the first edge after release, only stage 0 becomes valid. Fetch issues program counters starting at 0.
- R2: If a stage is valid and its main value differs from its shadow value, err_o for that stage is 1 in the cycle after the capturing edge.
- R3: A stage that holds a bubble (valid 0) never raises err_o, whatever its two samples contain.
- R4: When a stage takes an error, its main register is reloaded from the shadow and the stage holds. Its err_o is 0 in the following cycle. Every committed wb_data_o equals the late sample of the memory stage.
- R5: In the cycle after a stage takes an error, the next older stage holds a bubble. If the faulting stage is memory, wb_vld_o is 0 in that cycle instead.
- R6: An error taken at stage s in cycle c makes flush_o bit s-k equal 1 in cycle c+k, for k = 1..s. Exactly one flush bit is set per recovery.
- R7: restart_o is 1 in cycle c+s and 0 in the cycles before it. restart_pc_o equals the program counter of the faulting instruction plus 1, and fetch continues from that value.
- R8: The program counters on wb_pc_o are consecutive, starting at 0, whenever wb_vld_o is 1. No instruction is lost or repeated, whatever errors occur.
- R9: If several stages err in the same cycle, only the oldest one (highest index) recovers. The younger errors start no flush of their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ontime_i | input | NS*DW | Per-stage data arriving on time (main capture) |
| late_i | input | NS*DW | Per-stage data settled late (shadow capture) |
| err_o | output | NS | Per-stage timing error flag |
| vld_o | output | NS | Per-stage valid bit; 0 marks a bubble |
| flush_o | output | NS | Per-stage flush flag, travelling toward fetch |
| restart_o | output | 1 | Fetch restart request |
| restart_pc_o | output | PW | Program counter that fetch reloads |
| wb_vld_o | output | 1 | Writeback register holds a committed instruction |
| wb_pc_o | output | PW | Program counter of the committed instruction |
| wb_data_o | output | DW | Memory-stage data committed at writeback |

## Verification
The assertions assume that the late sample is always the correct value. They also assume that two recoveries are never in flight at the same time, because a second error inside the flush window would trigger a second, still correct, restart. The stimulus follows these limits. It holds every late input at a fixed per-stage constant. It creates errors only by corrupting the on-time value for a single cycle, and it waits long enough between injections for the pipeline to refill completely. Bubble stages are corrupted on purpose, to show that their errors are ignored.

// File: rtl/dsamp_pkg.sv
package dsamp_pkg;
  localparam int unsigned NUM_STG = 4;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned PC_W    = 12;

  function automatic logic [PC_W-1:0] pc_next(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction
endpackage

// File: rtl/dsamp_stage.sv
module dsamp_stage #(
  parameter int unsigned DW = 16,
  parameter int unsigned PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          up_vld_i,
  input  logic [PW-1:0] up_pc_i,
  input  logic [DW-1:0] ontime_i,
  input  logic [DW-1:0] late_i,
  input  logic          hold_i,
  input  logic          kill_i,
  output logic          vld_o,
  output logic [PW-1:0] pc_o,
  output logic [DW-1:0] data_o,
  output logic          err_o
);
  logic          vld_q;
  logic [PW-1:0] pc_q;
  logic [DW-1:0] main_q, shd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      pc_q   <= '0;
      main_q <= '0;
      shd_q  <= '0;
    end else if (hold_i) begin
      main_q <= shd_q;  // shadow is trusted; stay put one cycle
    end else if (kill_i) begin
      vld_q  <= 1'b0;
    end else begin
      vld_q  <= up_vld_i;
      pc_q   <= up_pc_i;
      main_q <= ontime_i;
      shd_q  <= late_i;
    end
  end

  assign vld_o  = vld_q;
  assign pc_o   = pc_q;
  assign data_o = main_q;
  assign err_o  = vld_q && (main_q != shd_q);

  // R4
  restore_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !err_o);
  // R4
  hold_keeps_instr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (vld_q && pc_q == $past(pc_q)));
endmodule

// File: rtl/dsamp_recover.sv
module dsamp_recover #(
  parameter int unsigned NS = 4,
  parameter int unsigned PW = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NS-1:0]          mism_i,
  input  logic [NS-1:0][PW-1:0]  pc_i,
  output logic [NS-1:0]          take_o,
  output logic [NS-1:0]          kill_o,
  output logic [NS-1:0]          flush_o,
  output logic                   restart_o,
  output logic [PW-1:0]          restart_pc_o
);
  import dsamp_pkg::*;

  logic [NS-1:0]         cand, take, flush_q, flush_d;
  logic [NS-1:0][PW-1:0] fpc_q, fpc_d;

  // a stage whose older neighbour is flushing is already doomed
  assign cand = mism_i & ~{1'b0, flush_q[NS-1:1]};

  always_comb begin
    logic older;
    older = 1'b0;
    for (int j = NS-1; j >= 0; j--) begin
      take[j] = cand[j] & ~older;
      older   = older | cand[j];
    end
  end

  always_comb begin
    flush_d = '0;
    fpc_d   = '0;
    for (int j = 0; j < NS-1; j++) begin
      flush_d[j] = flush_q[j+1] | take[j+1];
      fpc_d[j]   = take[j+1] ? pc_next(pc_i[j+1]) : fpc_q[j+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= '0;
      fpc_q   <= '0;
    end else begin
      flush_q <= flush_d;
      fpc_q   <= fpc_d;
    end
  end

  assign take_o       = take;
  assign kill_o       = flush_d | flush_q;
  assign flush_o      = flush_q;
  assign restart_o    = flush_q[0] | take[0];
  assign restart_pc_o = take[0] ? pc_next(pc_i[0]) : fpc_q[0];

  // R9
  single_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take));

  for (genvar j = 1; j < NS; j++) begin : g_fchk
    // R6
    flush_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take[j] |=> (flush_q[j-1] && fpc_q[j-1] == $past(pc_i[j]) + PW'(1)));
    // R6
    flush_walk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_q[j] |=> flush_q[j-1]);
  end
endmodule

// File: rtl/dsamp_fetch.sv
module dsamp_fetch #(
  parameter int unsigned PW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [PW-1:0] restart_pc_i,
  output logic [PW-1:0] pc_o
);
  import dsamp_pkg::*;

  logic [PW-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= '0;
    else if (restart_i) pc_q <= restart_pc_i;
    else                pc_q <= pc_next(pc_q);
  end

  assign pc_o = pc_q;

  // R7
  restart_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> pc_o == $past(restart_pc_i));
  // R8
  seq_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> pc_o == $past(pc_o) + PW'(1));
endmodule

// File: rtl/dsamp_pipe.sv
module dsamp_pipe #(
  parameter int unsigned NS = dsamp_pkg::NUM_STG,
  parameter int unsigned DW = dsamp_pkg::DATA_W,
  parameter int unsigned PW = dsamp_pkg::PC_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NS-1:0][DW-1:0] ontime_i,
  input  logic [NS-1:0][DW-1:0] late_i,
  output logic [NS-1:0]         err_o,
  output logic [NS-1:0]         vld_o,
  output logic [NS-1:0]         flush_o,
  output logic                  restart_o,
  output logic [PW-1:0]         restart_pc_o,
  output logic                  wb_vld_o,
  output logic [PW-1:0]         wb_pc_o,
  output logic [DW-1:0]         wb_data_o
);
  localparam int unsigned LAST = NS - 1;

  logic [NS-1:0]         vld, mism, take, kill;
  logic [NS-1:0][PW-1:0] pc;
  logic [NS-1:0][DW-1:0] sdata;
  logic [PW-1:0]         fe_pc, rs_pc;
  logic                  rs;

  dsamp_fetch #(.PW(PW)) u_fetch (
    .clk_i, .rst_ni,
    .restart_i    (rs),
    .restart_pc_i (rs_pc),
    .pc_o         (fe_pc)
  );

  for (genvar j = 0; j < NS; j++) begin : g_stg
    logic          up_vld;
    logic [PW-1:0] up_pc;
    if (j == 0) begin : g_head
      assign up_vld = 1'b1;
      assign up_pc  = fe_pc;
    end else begin : g_body
      assign up_vld = vld[j-1] & ~take[j-1];  // bubble past a faulting stage
      assign up_pc  = pc[j-1];
    end
    dsamp_stage #(.DW(DW), .PW(PW)) u_stg (
      .clk_i, .rst_ni,
      .up_vld_i (up_vld),
      .up_pc_i  (up_pc),
      .ontime_i (ontime_i[j]),
      .late_i   (late_i[j]),
      .hold_i   (take[j]),
      .kill_i   (kill[j]),
      .vld_o    (vld[j]),
      .pc_o     (pc[j]),
      .data_o   (sdata[j]),
      .err_o    (mism[j])
    );
  end

  dsamp_recover #(.NS(NS), .PW(PW)) u_rec (
    .clk_i, .rst_ni,
    .mism_i       (mism),
    .pc_i         (pc),
    .take_o       (take),
    .kill_o       (kill),
    .flush_o      (flush_o),
    .restart_o    (rs),
    .restart_pc_o (rs_pc)
  );

  // stabilizing writeback: no shadow, sees only checked values
  logic          wb_vld_q;
  logic [PW-1:0] wb_pc_q;
  logic [DW-1:0] wb_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_vld_q  <= 1'b0;
      wb_pc_q   <= '0;
      wb_data_q <= '0;
    end else begin
      wb_vld_q  <= vld[LAST] & ~take[LAST];
      wb_pc_q   <= pc[LAST];
      wb_data_q <= sdata[LAST];
    end
  end

  assign err_o        = mism;
  assign vld_o        = vld;
  assign restart_o    = rs;
  assign restart_pc_o = rs_pc;
  assign wb_vld_o     = wb_vld_q;
  assign wb_pc_o      = wb_pc_q;
  assign wb_data_o    = wb_data_q;

  // commit-order tracker for assertions only
  logic          seen_q;
  logic [PW-1:0] last_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (wb_vld_q) begin
      seen_q <= 1'b1;
      last_q <= wb_pc_q;
    end
  end

  // R8
  commit_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_vld_o && seen_q) |-> wb_pc_o == last_q + PW'(1));
  // R1
  first_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_vld_o && !seen_q) |-> wb_pc_o == '0);
  // R5
  wb_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take[LAST] |=> !wb_vld_o);

  for (genvar j = 0; j < NS-1; j++) begin : g_bchk
    // R5
    stage_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take[j] |=> !vld_o[j+1]);
  end
endmodule

// File: tb/sim_dsamp_pipe.sv
module sim_dsamp_pipe;
  localparam int NS = 4;
  localparam int DW = 16;
  localparam int PW = 12;

  logic                  clk = 1'b0;
  logic                  rst_ni = 1'b0;
  logic [NS-1:0][DW-1:0] ontime, late;
  logic [NS-1:0]         err_o, vld_o, flush_o;
  logic                  restart_o, wb_vld_o;
  logic [PW-1:0]         restart_pc_o, wb_pc_o;
  logic [DW-1:0]         wb_data_o;

  always #4 clk = ~clk;  // 125 MHz

  dsamp_pipe #(.NS(NS), .DW(DW), .PW(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ontime_i(ontime), .late_i(late),
    .err_o(err_o), .vld_o(vld_o), .flush_o(flush_o),
    .restart_o(restart_o), .restart_pc_o(restart_pc_o),
    .wb_vld_o(wb_vld_o), .wb_pc_o(wb_pc_o), .wb_data_o(wb_data_o)
  );

  int nchk = 0, nfail = 0, ncommit = 0;
  logic [PW-1:0] exp_q[$];

  function automatic logic [DW-1:0] kval(input int j);
    return DW'(16'hA000 + j * 16'h0111);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  // driver side of the scoreboard: expected commit stream
  task automatic push_expected(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(PW'(i));
  endtask

  // monitor: pop and compare each commit
  always @(negedge clk) begin
    if (rst_ni && wb_vld_o) begin
      ncommit++;
      if (exp_q.size() == 0) chk(1'b0, "R8", 32'(wb_pc_o), 32'hFFFF);
      else begin
        logic [PW-1:0] e;
        e = exp_q.pop_front();
        chk(wb_pc_o == e, "R8", 32'(wb_pc_o), 32'(e));
      end
      chk(wb_data_o == kval(NS-1), "R4", 32'(wb_data_o), 32'(kval(NS-1)));
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog act=timeout exp=finish");
    summary();
    $finish;
  end

  task automatic inject(input int s, input int s2);
    logic [PW-1:0] rp;
    int w;
    w = (s2 > s) ? s2 : s;
    ontime[s] = kval(s) ^ DW'(16'h005A);
    if (s2 >= 0) ontime[s2] = kval(s2) ^ DW'(16'h005A);
    @(negedge clk);  // cycle c
    ontime[s] = kval(s);
    if (s2 >= 0) ontime[s2] = kval(s2);
    chk(err_o[s] == 1'b1, "R2", 32'(err_o), 32'(s));
    if (s2 >= 0) chk(err_o[s2] == 1'b1, "R2", 32'(err_o), 32'(s2));
    chk(wb_vld_o == 1'b1, "R8", 32'(wb_vld_o), 1);
    rp = wb_pc_o + PW'(NS - w + 1);
    if (w < NS-1) ontime[w+1] = kval(w+1) ^ DW'(16'h00C3);  // corrupt bubble-bound stage
    if (w == 0) begin
      chk(restart_o == 1'b1, "R7", 32'(restart_o), 1);
      chk(restart_pc_o == rp, "R7", 32'(restart_pc_o), 32'(rp));
    end else chk(restart_o == 1'b0, "R7", 32'(restart_o), 0);
    for (int k = 1; k <= (w == 0 ? 1 : w); k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (w < NS-1) begin
          ontime[w+1] = kval(w+1);
          chk(vld_o[w+1] == 1'b0, "R5", 32'(vld_o), 0);
          chk(err_o[w+1] == 1'b0, "R3", 32'(err_o), 0);
        end else chk(wb_vld_o == 1'b0, "R5", 32'(wb_vld_o), 0);
        chk(err_o[w] == 1'b0, "R4", 32'(err_o), 0);
      end
      if (w > 0) begin
        chk(flush_o == NS'(1) << (w - k), (s2 >= 0) ? "R9" : "R6", 32'(flush_o), 32'(NS'(1) << (w - k)));
        chk(restart_o == (k == w), "R7", 32'(restart_o), 32'(k == w));
        if (k == w) chk(restart_pc_o == rp, "R7", 32'(restart_pc_o), 32'(rp));
      end
    end
    repeat (16) @(negedge clk);
  endtask

  initial begin
    for (int j = 0; j < NS; j++) begin
      ontime[j] = kval(j);
      late[j]   = kval(j);
    end
    push_expected(400);
    repeat (3) @(negedge clk);
    // R1
    chk(vld_o == '0 && flush_o == '0 && err_o == '0, "R1", 32'({vld_o, flush_o, err_o}), 0);
    chk(restart_o == 1'b0 && wb_vld_o == 1'b0, "R1", 32'({restart_o, wb_vld_o}), 0);
    rst_ni = 1'b1;
    for (int j = 1; j < NS; j++) ontime[j] = kval(j) ^ DW'(16'h00FF);
    @(negedge clk);
    chk(vld_o == NS'(1), "R1", 32'(vld_o), 1);
    chk(err_o == '0, "R3", 32'(err_o), 0);
    for (int j = 1; j < NS; j++) ontime[j] = kval(j);
    repeat (15) @(negedge clk);
    for (int s = 0; s < NS; s++) inject(s, -1);
    inject(1, 3);  // R9: oldest wins
    inject(0, 2);  // R9
    repeat (20) @(negedge clk);
    chk(ncommit >= 60, "R8", 32'(ncommit), 60);
    summary();
    $finish;
  end
endmodule